// File: doc/BRIEF.md
# Command-Gated Serial Register Slave

The block is a serial slave for a converter-style front end. It owns a small bank of 8-bit configuration registers, two wide calibration registers and a wide sample register. A host reaches any of them only by first shifting in an 8-bit command byte. The command byte picks the direction and the register address, and the transfer to or from that register starts on the very next serial clock. The wide registers are 16 or 24 bits, chosen by `DW`, and move as whole bytes with the most significant byte first.

New conversion results arrive on a parallel port with a one-cycle strobe. The block raises the active-low ready line while it is updating the sample register, loads the word, then drops ready to signal fresh data. A completed serial read of the sample register raises ready again, but the word stays readable. A host that has lost framing can hold data-in at 1 for 32 serial clocks to return the interface and every register to its power-on state. The serial pins are oversampled by the system clock, so `clk_i` must run at least about six times faster than the serial clock.

Top module: `sreg_serial_slave`

## Requirements
- R1: After reset, `rdy_no` is 1, `sdo_oe_o` is 0 and the block waits for a command byte. The registers hold their power-on values: address 1 = 0x00, 2 = 0x07, 3 = 0x45, 4 (sample) = 0, 5 = 1<<(DW-1), 6 = 1<<(DW-2), 7 = 0x4A.
- R2: The command byte is sent MSB first and its fields are decoded as follows:
  - Bit 7 must be 0. If bit 7 is 1, the whole byte is ignored and the next 8 bits are taken as a new command byte.
  - Bit 6 is 1 for a read and 0 for a write.
  - Bits 3..0 give the address. Bits 5..4 are ignored.
- R3: The data transfer begins on the serial clock right after the 8th command bit, with no gap. A command plus an 8-bit write is one continuous 16-clock frame. Addresses 4, 5 and 6 transfer DW/8 bytes MSB first; every other address transfers one byte. Chip select may stay low across several transactions.
- R4: Addresses 0, 4 and 7 are read-only and writes to them are ignored. Addresses 8 to 15 are unmapped: they read as 0 and ignore writes. Addresses 1, 2, 3, 5 and 6 read back what was last written.
- R5: Data-in is sampled on the rising edge of `sclk_i` and `sdo_o` changes only after falling edges. `sdo_oe_o` is 1 only during a read transfer with chip select low. Data-in is ignored during a read transfer.
- R6: Data-in at 1 on 32 consecutive rising edges outside a read transfer does two things: the frame returns to waiting for a command, and all registers go back to their R1 values with `rdy_no` at 1. A run of 31 ones has no such effect.
- R7: Raising `cs_ni` in the middle of a transfer aborts it without any register change. The next frame starts with a command byte.
- R8: One cycle after a `smp_vld_i` strobe, `rdy_no` is 1 and `smp_load_o` pulses; this holds even if `rdy_no` was 0 before. One cycle later the sample register holds the strobed word and `rdy_no` is 0.
- R9: A completed read of address 4 sets `rdy_no` to 1. Status register bit 7 (address 0) reads as the inverse of `rdy_no`; its other bits read 0.
- R10: Reading the sample register again before the next strobe returns the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock, idles high |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Pad driver enable for sdo_o (0 = high impedance) |
| rdy_no | output | 1 | Active-low data ready |
| smp_vld_i | input | 1 | Strobe: new sample on smp_data_i |
| smp_data_i | input | DW | New sample word |
| smp_load_o | output | 1 | Pulses in the cycle the sample register takes the word |

## Verification
A bit counter that is off by one makes every later command in the same frame land on a shifted byte boundary. That shows up within a single transaction as wrong read-back data or a wrong register being written, which is why several transactions run with chip select held low. A run-of-ones counter that is not cleared by zeros, or not held off during reads, resets the registers early; the 31-versus-32 and read-with-ones cases expose this on the next read. A stale ready state shows on `rdy_no` within two system cycles of a strobe and, in the status register, on the next status read.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  typedef enum logic [1:0] {
    ST_CMD = 2'd0,
    ST_WR  = 2'd1,
    ST_RD  = 2'd2
  } fr_state_e;

  localparam logic [3:0] A_STAT = 4'h0;
  localparam logic [3:0] A_MODE = 4'h1;
  localparam logic [3:0] A_CHAN = 4'h2;
  localparam logic [3:0] A_FILT = 4'h3;
  localparam logic [3:0] A_DATA = 4'h4;
  localparam logic [3:0] A_OFFS = 4'h5;
  localparam logic [3:0] A_GAIN = 4'h6;
  localparam logic [3:0] A_IDNT = 4'h7;

  localparam int         N_NARROW = 3;
  localparam int         N_WIDE   = 2;
  localparam logic [7:0] ID_VAL   = 8'h4A;

  function automatic logic [7:0] narrow_por(input int idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'h07;
      default: return 8'h45;
    endcase
  endfunction

  function automatic logic is_wide(input logic [3:0] a);
    return (a == A_DATA) || (a == A_OFFS) || (a == A_GAIN);
  endfunction

endpackage

// File: rtl/sreg_pins.sv
module sreg_pins #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic cs_act_o,
  output logic rise_o,
  output logic fall_o,
  output logic sdi_o
);
  localparam int         NPIN = 3;
  localparam logic [2:0] IDLE = 3'b011;  // {sdi, sclk, cs} idle levels

  logic [NPIN-1:0] raw, synced;
  logic            sclk_d;

  assign raw = {sdi_i, sclk_i, cs_ni};

  for (genvar b = 0; b < NPIN; b++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= {SYNC_STAGES{IDLE[b]}};
      else         chain <= {chain[SYNC_STAGES-2:0], raw[b]};
    end
    assign synced[b] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b1;
    else         sclk_d <= synced[1];
  end

  assign rise_o   = synced[1] & ~sclk_d;
  assign fall_o   = ~synced[1] & sclk_d;
  assign cs_act_o = ~synced[0];
  assign sdi_o    = synced[2];

endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
  import sreg_pkg::*;
#(
  parameter int DW      = 24,
  parameter int RUN_LEN = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_act_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          sdi_i,
  input  logic [DW-1:0] rd_word_i,
  output logic [3:0]    sel_addr_o,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_data_o,
  output logic          rd_done_o,
  output logic          soft_rst_o,
  output logic          sdo_o,
  output logic          sdo_oe_o
);
  localparam int CW = $clog2(DW);
  localparam int OW = $clog2(RUN_LEN + 1);

  fr_state_e     state_q;
  logic [CW-1:0] bcnt_q, last_bit;
  logic [DW-1:0] sh_q, rd_aligned;
  logic [3:0]    addr_q;
  logic [OW-1:0] ones_q;
  logic [7:0]    cmd_byte;
  logic          at_last;

  assign cmd_byte   = {sh_q[6:0], sdi_i};
  assign last_bit   = is_wide(addr_q) ? CW'(DW - 1) : CW'(7);
  assign at_last    = (bcnt_q == last_bit);
  assign sel_addr_o = (state_q == ST_CMD) ? cmd_byte[3:0] : addr_q;
  // narrow registers leave the MSB of the shifter first
  assign rd_aligned = is_wide(cmd_byte[3:0]) ? rd_word_i
                                             : {rd_word_i[7:0], {(DW-8){1'b0}}};

  assign soft_rst_o = cs_act_i & rise_i & sdi_i & (state_q != ST_RD)
                    & (ones_q == OW'(RUN_LEN - 1));
  assign wr_en_o    = cs_act_i & rise_i & (state_q == ST_WR) & at_last & ~soft_rst_o;
  assign wr_data_o  = {sh_q[DW-2:0], sdi_i};
  assign rd_done_o  = cs_act_i & rise_i & (state_q == ST_RD) & at_last;
  assign sdo_o      = sh_q[DW-1];
  assign sdo_oe_o   = cs_act_i & (state_q == ST_RD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      bcnt_q  <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      ones_q  <= '0;
    end else if (!cs_act_i) begin
      state_q <= ST_CMD;
      bcnt_q  <= '0;
      ones_q  <= '0;
    end else if (soft_rst_o) begin
      state_q <= ST_CMD;
      bcnt_q  <= '0;
      ones_q  <= '0;
      sh_q    <= '0;
    end else if (rise_i) begin
      ones_q <= (state_q != ST_RD && sdi_i) ? ones_q + 1'b1 : '0;
      case (state_q)
        ST_CMD: begin
          sh_q <= {sh_q[DW-2:0], sdi_i};
          if (bcnt_q == CW'(7)) begin
            bcnt_q <= '0;
            if (!cmd_byte[7]) begin
              addr_q <= cmd_byte[3:0];
              if (cmd_byte[6]) begin
                state_q <= ST_RD;
                sh_q    <= rd_aligned;
              end else begin
                state_q <= ST_WR;
                sh_q    <= '0;
              end
            end
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
        ST_WR: begin
          sh_q <= {sh_q[DW-2:0], sdi_i};
          if (at_last) begin
            state_q <= ST_CMD;
            bcnt_q  <= '0;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
        default: begin
          if (at_last) begin
            state_q <= ST_CMD;
            bcnt_q  <= '0;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
      endcase
    end else if (fall_i && state_q == ST_RD && bcnt_q != '0) begin
      sh_q <= {sh_q[DW-2:0], 1'b0};
    end
  end

  p_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> (state_q == ST_CMD) && (bcnt_q == '0));

  p_sdo_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD) && !fall_i |=> $stable(sdo_o));

  p_resync_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (state_q == ST_CMD) && (bcnt_q == '0) && (ones_q == '0));

  p_cmd_bits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMD) |-> bcnt_q <= CW'(7));

  p_xfer_bits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_CMD) |-> bcnt_q <= last_bit);

endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          wr_en_i,
  input  logic [3:0]    addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_done_i,
  input  logic          smp_vld_i,
  input  logic [DW-1:0] smp_data_i,
  output logic [DW-1:0] rd_word_o,
  output logic          rdy_no,
  output logic          load_o
);
  localparam logic [DW-1:0] OFFS_POR = DW'(1) << (DW - 1);
  localparam logic [DW-1:0] GAIN_POR = DW'(1) << (DW - 2);

  logic [N_NARROW-1:0][7:0]    nr_v;
  logic [N_WIDE-1:0][DW-1:0]   wd_v;
  logic [DW-1:0]               dat_q, hold_q;
  logic                        rdy_nq, pend_q;
  logic [1:0]                  nidx;

  for (genvar g = 0; g < N_NARROW; g++) begin : g_nr
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  q <= narrow_por(g);
      else if (soft_rst_i)                          q <= narrow_por(g);
      else if (wr_en_i && addr_i == A_MODE + 4'(g)) q <= wr_data_i[7:0];
    end
    assign nr_v[g] = q;
  end

  for (genvar g = 0; g < N_WIDE; g++) begin : g_wd
    localparam logic [DW-1:0] POR = (g == 0) ? OFFS_POR : GAIN_POR;
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  q <= POR;
      else if (soft_rst_i)                          q <= POR;
      else if (wr_en_i && addr_i == A_OFFS + 4'(g)) q <= wr_data_i;
    end
    assign wd_v[g] = q;
  end

  // ready goes high for the update cycle, low once the word is in place
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_nq <= 1'b1;
      pend_q <= 1'b0;
      dat_q  <= '0;
      hold_q <= '0;
    end else if (soft_rst_i) begin
      rdy_nq <= 1'b1;
      pend_q <= 1'b0;
      dat_q  <= '0;
      hold_q <= '0;
    end else begin
      pend_q <= smp_vld_i;
      if (smp_vld_i) hold_q <= smp_data_i;
      if (pend_q) begin
        dat_q  <= hold_q;
        rdy_nq <= 1'b0;
      end else if (smp_vld_i) begin
        rdy_nq <= 1'b1;
      end else if (rd_done_i && addr_i == A_DATA) begin
        rdy_nq <= 1'b1;
      end
    end
  end

  assign rdy_no = rdy_nq;
  assign load_o = pend_q;
  assign nidx   = 2'(addr_i - A_MODE);

  always_comb begin
    rd_word_o = '0;
    case (addr_i)
      A_STAT:                 rd_word_o[7]   = ~rdy_nq;
      A_MODE, A_CHAN, A_FILT: rd_word_o[7:0] = nr_v[nidx];
      A_DATA:                 rd_word_o      = dat_q;
      A_OFFS:                 rd_word_o      = wd_v[0];
      A_GAIN:                 rd_word_o      = wd_v[1];
      A_IDNT:                 rd_word_o[7:0] = ID_VAL;
      default:                rd_word_o      = '0;
    endcase
  end

  p_upd_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i && !pend_q && !soft_rst_i |=> rdy_no && load_o);

  p_load_lo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o && !soft_rst_i |=> !rdy_no && (dat_q == $past(hold_q)));

  p_rd_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_i && (addr_i == A_DATA) && !pend_q && !smp_vld_i && !soft_rst_i |=> rdy_no);

  p_por_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> rdy_no && (dat_q == '0) && (wd_v[0] == OFFS_POR) && (nr_v[1] == narrow_por(1)));

endmodule

// File: rtl/sreg_serial_slave.sv
module sreg_serial_slave
  import sreg_pkg::*;
#(
  parameter int DW          = 24,
  parameter int SYNC_STAGES = 2,
  parameter int RUN_LEN     = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          sclk_i,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic          rdy_no,
  input  logic          smp_vld_i,
  input  logic [DW-1:0] smp_data_i,
  output logic          smp_load_o
);
  logic          cs_act, rise, fall, sdi_s;
  logic [3:0]    sel_addr;
  logic          wr_en, rd_done, soft_rst;
  logic [DW-1:0] wr_data, rd_word;

  sreg_pins #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .sclk_i   (sclk_i),
    .sdi_i    (sdi_i),
    .cs_act_o (cs_act),
    .rise_o   (rise),
    .fall_o   (fall),
    .sdi_o    (sdi_s)
  );

  sreg_frame #(.DW(DW), .RUN_LEN(RUN_LEN)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .rise_i     (rise),
    .fall_i     (fall),
    .sdi_i      (sdi_s),
    .rd_word_i  (rd_word),
    .sel_addr_o (sel_addr),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .rd_done_o  (rd_done),
    .soft_rst_o (soft_rst),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o)
  );

  sreg_bank #(.DW(DW)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .wr_en_i    (wr_en),
    .addr_i     (sel_addr),
    .wr_data_i  (wr_data),
    .rd_done_i  (rd_done),
    .smp_vld_i  (smp_vld_i),
    .smp_data_i (smp_data_i),
    .rd_word_o  (rd_word),
    .rdy_no     (rdy_no),
    .load_o     (smp_load_o)
  );

endmodule

// File: tb/tb_sreg_serial_slave.sv
`timescale 1ns/1ps
module tb_sreg_serial_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic        sdo, sdo_oe, rdy_n, smp_load;
  logic        smp_vld = 1'b0;
  logic [23:0] smp_data = '0;
  int          n_chk = 0, n_fail = 0;
  logic        oe_any = 1'b0;

  always #2 clk = ~clk;

  sreg_serial_slave #(.DW(24)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .rdy_no(rdy_n),
    .smp_vld_i(smp_vld), .smp_data_i(smp_data), .smp_load_o(smp_load)
  );

  // {addr, write data, expected read-back}
  localparam logic [51:0] VEC [8] = '{
    52'h1_000012_000012, 52'h2_0000A5_0000A5, 52'h3_00003C_00003C,
    52'h5_123456_123456, 52'h6_ABCDEF_ABCDEF, 52'h7_0000FF_00004A,
    52'h9_000077_000000, 52'h4_111111_000000
  };

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [3:0] a);
    return (a == 4'h4 || a == 4'h5 || a == 4'h6) ? 3 : 1;
  endfunction

  task automatic sbit(input logic b, output logic so);
    sdi = b; sclk = 1'b0;
    repeat (4) @(negedge clk);
    oe_any |= sdo_oe;
    repeat (4) @(negedge clk);
    so = sdo; sclk = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic s;
      sbit(tx[i], s);
      rx[i] = s;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0; repeat (6) @(negedge clk);
  endtask

  task automatic cs_hi();
    cs_n = 1'b1; sclk = 1'b1; repeat (8) @(negedge clk);
  endtask

  task automatic wr_raw(input logic [3:0] a, input logic [23:0] d);
    logic [7:0] r;
    int nb;
    nb = nbytes(a);
    sbyte({4'b0000, a}, r);
    for (int k = 0; k < nb; k++) sbyte(8'(d >> (8 * (nb - 1 - k))), r);
  endtask

  task automatic rd_raw(input logic [3:0] a, input logic [7:0] fill, output logic [23:0] v);
    logic [7:0] r;
    int nb;
    nb = nbytes(a);
    v = '0;
    sbyte({4'b0100, a}, r);
    for (int k = 0; k < nb; k++) begin
      sbyte(fill, r);
      v = {v[15:0], r};
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [23:0] d);
    cs_lo(); wr_raw(a, d); cs_hi();
  endtask

  task automatic rd_reg(input logic [3:0] a, input logic [7:0] fill, output logic [23:0] v);
    cs_lo(); rd_raw(a, fill, v); cs_hi();
  endtask

  task automatic ones(input int n);
    logic s;
    for (int i = 0; i < n; i++) sbit(1'b1, s);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin : main
    logic [23:0] v;
    logic [7:0]  r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 rdy_no after reset", 24'(rdy_n), 24'h1);
    chk("R1 sdo_oe after reset", 24'(sdo_oe), 24'h0);
    chk("R1 load strobe idle", 24'(smp_load), 24'h0);
    rd_reg(4'h1, 8'h00, v); chk("R1 reg1 por", v, 24'h00);
    rd_reg(4'h2, 8'h00, v); chk("R1 reg2 por", v, 24'h07);
    rd_reg(4'h3, 8'h00, v); chk("R1 reg3 por", v, 24'h45);
    rd_reg(4'h4, 8'h00, v); chk("R1 sample por", v, 24'h0);
    rd_reg(4'h5, 8'h00, v); chk("R1 offset por", v, 24'h800000);
    rd_reg(4'h6, 8'h00, v); chk("R1 gain por", v, 24'h400000);
    rd_reg(4'h7, 8'h00, v); chk("R1 id", v, 24'h4A);
    rd_reg(4'h0, 8'h00, v); chk("R9 status no data", v, 24'h00);

    // vector walk: write then read back
    foreach (VEC[i]) begin
      logic [3:0] a;
      a = VEC[i][51:48];
      wr_reg(a, VEC[i][47:24]);
      rd_reg(a, 8'h00, v);
      chk((a inside {4'h1, 4'h2, 4'h3, 4'h5, 4'h6}) ? "R3 rw readback" : "R4 read-only or unmapped",
          v, VEC[i][23:0]);
    end

    // R5 half duplex
    oe_any = 1'b0;
    wr_reg(4'h1, 24'h21);
    chk("R5 sdo_oe low during write", 24'(oe_any), 24'h0);
    oe_any = 1'b0;
    rd_reg(4'h5, 8'hA5, v);
    chk("R5 read ignores sdi pattern A5", v, 24'h123456);
    chk("R5 sdo_oe high during read", 24'(oe_any), 24'h1);
    rd_reg(4'h5, 8'hFF, v);
    chk("R5 read ignores sdi ones", v, 24'h123456);
    chk("R5 sdo_oe low with cs high", 24'(sdo_oe), 24'h0);

    // R3 three-wire: several transactions in one cs-low frame
    cs_lo();
    wr_raw(4'h3, 24'h6B);
    rd_raw(4'h3, 8'h00, v);
    chk("R3 back-to-back in one frame", v, 24'h6B);
    wr_raw(4'h6, 24'h0F1E2D);
    rd_raw(4'h6, 8'h00, v);
    chk("R3 wide MSB first in one frame", v, 24'h0F1E2D);
    cs_hi();

    // R2 invalid command byte then valid one
    cs_lo();
    sbyte(8'h81, r); sbyte(8'h01, r); sbyte(8'h5A, r);
    cs_hi();
    rd_reg(4'h1, 8'h00, v); chk("R2 guard bit byte ignored", v, 24'h5A);
    // R2 bits 5..4 ignored
    cs_lo(); sbyte(8'h32, r); sbyte(8'h3C, r); cs_hi();
    rd_reg(4'h2, 8'h00, v); chk("R2 addr bits 5..4 ignored", v, 24'h3C);

    // R7 abort mid-write
    cs_lo();
    sbyte(8'h02, r);
    sbit(1'b1, r[0]); sbit(1'b0, r[0]); sbit(1'b1, r[0]); sbit(1'b0, r[0]);
    cs_hi();
    rd_reg(4'h2, 8'h00, v); chk("R7 aborted write keeps reg2", v, 24'h3C);

    // R8 sample load sequence
    @(negedge clk); smp_vld = 1'b1; smp_data = 24'hC0FFEE;
    @(negedge clk); smp_vld = 1'b0;
    chk("R8 rdy high during update", 24'(rdy_n), 24'h1);
    chk("R8 load strobe", 24'(smp_load), 24'h1);
    @(negedge clk);
    chk("R8 rdy low after load", 24'(rdy_n), 24'h0);
    chk("R8 load strobe single", 24'(smp_load), 24'h0);
    rd_reg(4'h0, 8'h00, v); chk("R9 status shows new data", v, 24'h80);
    rd_reg(4'h4, 8'hFF, v); chk("R8 sample word", v, 24'hC0FFEE);
    chk("R9 rdy high after data read", 24'(rdy_n), 24'h1);
    rd_reg(4'h0, 8'h00, v); chk("R9 status cleared", v, 24'h00);
    rd_reg(4'h4, 8'h00, v); chk("R10 reread same word", v, 24'hC0FFEE);

    // R8 update while ready is low
    @(negedge clk); smp_vld = 1'b1; smp_data = 24'h0BEEF1;
    @(negedge clk); smp_vld = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 rdy low before second update", 24'(rdy_n), 24'h0);
    smp_vld = 1'b1; smp_data = 24'h123ABC;
    @(negedge clk); smp_vld = 1'b0;
    chk("R8 rdy rises before update", 24'(rdy_n), 24'h1);
    @(negedge clk);
    chk("R8 rdy low after second load", 24'(rdy_n), 24'h0);
    rd_reg(4'h4, 8'h00, v); chk("R8 second sample word", v, 24'h123ABC);
    rd_reg(4'h4, 8'h00, v); chk("R10 second reread", v, 24'h123ABC);

    // R6 31 ones do nothing
    wr_reg(4'h1, 24'h99);
    cs_lo(); ones(31); cs_hi();
    rd_reg(4'h1, 8'h00, v); chk("R6 31 ones keep reg1", v, 24'h99);

    // R6 32 ones reset interface and registers
    @(negedge clk); smp_vld = 1'b1; smp_data = 24'h777777;
    @(negedge clk); smp_vld = 1'b0;
    repeat (2) @(negedge clk);
    cs_lo();
    ones(32);
    rd_raw(4'h2, 8'h00, v);
    chk("R6 reg2 por after ones, same frame", v, 24'h07);
    cs_hi();
    chk("R6 rdy high after ones", 24'(rdy_n), 24'h1);
    rd_reg(4'h1, 8'h00, v); chk("R6 reg1 por", v, 24'h00);
    rd_reg(4'h6, 8'h00, v); chk("R6 gain por", v, 24'h400000);
    rd_reg(4'h4, 8'h00, v); chk("R6 sample cleared", v, 24'h0);

    summary();
    $finish;
  end
endmodule